// File: doc/BRIEF.md
# SDRAM Read Latency and Byte Mask Data Path

This block is the data side of a 16-bit synchronous DRAM device. A command decoder hands it one-cycle strobes for read, write, burst stop and precharge, plus a flag marking the last beat of a burst. The address generator and cell array sit outside. During a read burst, the block takes one word per clock from the array port. It delays each word by the programmed read latency of two or three clocks, then drives it onto the data bus through a pair of per-byte output enables. During a write burst, it captures the bus word on the same edge as the command and presents it to the array port as a one-cycle write strobe with per-byte enables.

The two byte-mask inputs act on the two directions with different timing. On a read, a mask bit removes its byte from the bus two clocks after it is sampled. On a write, it removes its byte from the array write on the edge where it is sampled. A burst stop or a precharge ends the current burst. The words already in the latency pipeline still drain, so the bus floats a number of clocks after the command equal to the read latency. A write that cuts into a read discards the words still in flight.

Top module: `sdr_dq_path`

## Requirements
- R1: Reset (rst_ni low, asynchronous) forces dq_oe_o and arr_we_o to zero at once, and leaves the read latency at three clocks.
- R2: A read word taken from rdata_i at rising edge E is on dq_o with dq_oe_o high in the clock period that starts at edge E+L-1, where L is the programmed latency (2 or 3). The host therefore samples it at edge E+L.
- R3: A read or write command at an edge starts a burst that moves one word per edge, the command edge included, up to and including the edge where burst_end_i is high. Commands are one-hot per edge.
- R4: dqm_i bit b high at edge E turns off dq_oe_o bit b in the period starting at edge E+1. Bit 1 controls dq[15:8] and bit 0 controls dq[7:0].
- R5: At each write-beat edge, the next period shows arr_we_o=1, arr_wdata_o equal to dq_i, and arr_be_o equal to the inverse of dqm_i. In periods after edges without a write beat, arr_we_o is 0.
- R6: A burst stop moves no read word at its own edge. With latency L, dq_oe_o is zero in the period that starts L-1 edges after the stop, unless a later read fills it.
- R7: A precharge ends a read or write burst the same way as a burst stop. The bus floats L clocks after it: sampled 3 clocks later at latency 3, 2 clocks later at latency 2.
- R8: A write command empties the read pipeline, so dq_oe_o is zero in the periods that follow it until a later read word emerges.
- R9: mode_cl3_i (1 selects latency 3, 0 selects latency 2) is taken only on an edge where mode_set_i is high. At all other times it has no effect on read timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_set_i | input | 1 | Load read latency from mode_cl3_i |
| mode_cl3_i | input | 1 | Latency select: 1 = three clocks, 0 = two clocks |
| rd_cmd_i | input | 1 | Read command strobe |
| wr_cmd_i | input | 1 | Write command strobe |
| stop_cmd_i | input | 1 | Burst stop strobe |
| pre_cmd_i | input | 1 | Precharge strobe |
| burst_end_i | input | 1 | Current beat is the last of its burst |
| dqm_i | input | 2 | Byte masks, bit 1 upper byte, bit 0 lower byte |
| rdata_i | input | 16 | Word from the array for the current read beat |
| dq_i | input | 16 | Data bus input for writes |
| dq_o | output | 16 | Data bus output for reads |
| dq_oe_o | output | 2 | Per-byte bus drive enable |
| arr_we_o | output | 1 | Array write strobe |
| arr_be_o | output | 2 | Array write byte enables |
| arr_wdata_o | output | 16 | Array write word |

## Verification
The properties assume the decoder never raises two of read, write, stop, precharge and mode load on one edge. They also assume the latency is reloaded only while the pipeline is idle, because a reload mid-burst would move the output tap under words already in flight. The stimulus keeps to these rules: every vector carries at most one strobe, and mode loads happen only after a few idle clocks. All timing expectations are counted by hand from the command edge.

// File: rtl/sdr_dq_pkg.sv
package sdr_dq_pkg;
  parameter int unsigned DQ_W     = 16;
  parameter int unsigned MAX_CL   = 3;
  parameter int unsigned MASK_DLY = 2;

  typedef enum logic [1:0] {
    BURST_IDLE = 2'd0,
    BURST_RD   = 2'd1,
    BURST_WR   = 2'd2
  } burst_e;
endpackage

// File: rtl/sdr_lat_pipe.sv
module sdr_lat_pipe #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 3,
  parameter int unsigned TAP_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_vld_i,
  input  logic [DW-1:0]    in_data_i,
  input  logic             flush_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             out_vld_o,
  output logic [DW-1:0]    out_data_o
);
  logic [DEPTH-1:0] vld_q, vld_d, dat_en;
  logic [DW-1:0]    dat_q [DEPTH];
  logic [DW-1:0]    dat_d [DEPTH];

  // next-state: shift valid flags, flush drops everything in flight
  always_comb begin
    vld_d[0]  = in_vld_i & ~flush_i;
    dat_en[0] = in_vld_i;
    dat_d[0]  = in_data_i;
    for (int k = 1; k < DEPTH; k++) begin
      vld_d[k]  = vld_q[k-1] & ~flush_i;
      dat_en[k] = vld_q[k-1];
      dat_d[k]  = dat_q[k-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= vld_d;
  end

  // data stages carry no reset; each loads only when a word moves in
  always_ff @(posedge clk_i) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (dat_en[k]) dat_q[k] <= dat_d[k];
    end
  end

  assign out_vld_o  = vld_q[tap_i];
  assign out_data_o = dat_q[tap_i];
endmodule

// File: rtl/sdr_mask_dly.sv
module sdr_mask_dly #(
  parameter int unsigned NB  = 2,
  parameter int unsigned DLY = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] mask_i,
  output logic [NB-1:0] mask_o
);
  logic [NB-1:0] stg_q [DLY];
  logic [NB-1:0] stg_d [DLY];

  always_comb begin
    stg_d[0] = mask_i;
    for (int k = 1; k < DLY; k++) stg_d[k] = stg_q[k-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DLY; k++) stg_q[k] <= '0;
    end else begin
      for (int k = 0; k < DLY; k++) stg_q[k] <= stg_d[k];
    end
  end

  assign mask_o = stg_q[DLY-1];
endmodule

// File: rtl/sdr_wr_cap.sv
module sdr_wr_cap #(
  parameter int unsigned DW = 16,
  parameter int unsigned NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          beat_i,
  input  logic [NB-1:0] mask_i,
  input  logic [DW-1:0] dq_i,
  output logic          we_o,
  output logic [NB-1:0] be_o,
  output logic [DW-1:0] wdata_o
);
  logic          we_q, we_d;
  logic [NB-1:0] be_q, be_d;
  logic [DW-1:0] wdata_q;

  always_comb begin
    we_d = beat_i;
    be_d = beat_i ? ~mask_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b0;
      be_q <= '0;
    end else begin
      we_q <= we_d;
      be_q <= be_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (beat_i) wdata_q <= dq_i;
  end

  assign we_o    = we_q;
  assign be_o    = be_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/sdr_dq_path.sv
module sdr_dq_path
  import sdr_dq_pkg::*;
#(
  parameter int unsigned DW     = DQ_W,
  parameter int unsigned CL_MAX = MAX_CL
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_set_i,
  input  logic               mode_cl3_i,
  input  logic               rd_cmd_i,
  input  logic               wr_cmd_i,
  input  logic               stop_cmd_i,
  input  logic               pre_cmd_i,
  input  logic               burst_end_i,
  input  logic [DW/8-1:0]    dqm_i,
  input  logic [DW-1:0]      rdata_i,
  input  logic [DW-1:0]      dq_i,
  output logic [DW-1:0]      dq_o,
  output logic [DW/8-1:0]    dq_oe_o,
  output logic               arr_we_o,
  output logic [DW/8-1:0]    arr_be_o,
  output logic [DW-1:0]      arr_wdata_o
);
  localparam int unsigned NB    = DW / 8;
  localparam int unsigned TAP_W = $clog2(CL_MAX);
  localparam logic [TAP_W-1:0] TAP_LONG  = TAP_W'(CL_MAX - 1);
  localparam logic [TAP_W-1:0] TAP_SHORT = TAP_W'(CL_MAX - 2);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // latency select, loaded only on a mode load
  logic lat3_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)          lat3_q <= 1'b1;
    else if (mode_set_i) lat3_q <= mode_cl3_i;
  end

  // burst tracking
  burst_e state_q, state_d;
  logic   halt, rd_beat, wr_beat;

  assign halt    = stop_cmd_i | pre_cmd_i;
  assign rd_beat = rd_cmd_i | ((state_q == BURST_RD) & ~wr_cmd_i & ~halt);
  assign wr_beat = wr_cmd_i | ((state_q == BURST_WR) & ~rd_cmd_i & ~halt);

  always_comb begin
    state_d = state_q;
    if (rd_cmd_i)                              state_d = burst_end_i ? BURST_IDLE : BURST_RD;
    else if (wr_cmd_i)                         state_d = burst_end_i ? BURST_IDLE : BURST_WR;
    else if (halt)                             state_d = BURST_IDLE;
    else if (state_q != BURST_IDLE && burst_end_i) state_d = BURST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) state_q <= BURST_IDLE;
    else        state_q <= state_d;
  end

  // read latency pipeline
  logic             pipe_vld;
  logic [DW-1:0]    pipe_data;
  logic [TAP_W-1:0] tap_sel;
  assign tap_sel = lat3_q ? TAP_LONG : TAP_SHORT;

  sdr_lat_pipe #(.DW(DW), .DEPTH(CL_MAX), .TAP_W(TAP_W)) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .in_vld_i   (rd_beat),
    .in_data_i  (rdata_i),
    .flush_i    (wr_beat),
    .tap_i      (tap_sel),
    .out_vld_o  (pipe_vld),
    .out_data_o (pipe_data)
  );

  // read byte masks act two clocks late
  logic [NB-1:0] rd_mask;
  sdr_mask_dly #(.NB(NB), .DLY(MASK_DLY)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .mask_i (dqm_i),
    .mask_o (rd_mask)
  );

  for (genvar b = 0; b < NB; b++) begin : g_byte_oe
    assign dq_oe_o[b] = pipe_vld & ~rd_mask[b];
  end
  assign dq_o = pipe_data;

  // write capture, masks act on the same edge
  sdr_wr_cap #(.DW(DW), .NB(NB)) u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .beat_i  (wr_beat),
    .mask_i  (dqm_i),
    .dq_i    (dq_i),
    .we_o    (arr_we_o),
    .be_o    (arr_be_o),
    .wdata_o (arr_wdata_o)
  );
endmodule

// File: rtl/sdr_dq_path_chk.sv
module sdr_dq_path_chk #(
  parameter int unsigned DW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mode_set_i,
  input logic            rd_cmd_i,
  input logic            wr_cmd_i,
  input logic            stop_cmd_i,
  input logic            pre_cmd_i,
  input logic [DW/8-1:0] dqm_i,
  input logic [DW-1:0]   rdata_i,
  input logic [DW-1:0]   dq_i,
  input logic [DW-1:0]   dq_o,
  input logic [DW/8-1:0] dq_oe_o,
  input logic            arr_we_o,
  input logic [DW/8-1:0] arr_be_o,
  input logic [DW-1:0]   arr_wdata_o,
  input logic            lat3_q
);
  AST_CMD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_cmd_i, wr_cmd_i, stop_cmd_i, pre_cmd_i, mode_set_i})); // R3

  AST_RD_CL2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cmd_i && !lat3_q && dqm_i == '0) ##1 (!wr_cmd_i && !mode_set_i)
    |=> (dq_oe_o == '1 && dq_o == $past(rdata_i, 2))); // R2

  AST_RD_CL3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cmd_i && lat3_q) ##1 (!wr_cmd_i && !mode_set_i && dqm_i == '0) ##1 (!wr_cmd_i && !mode_set_i)
    |=> (dq_oe_o == '1 && dq_o == $past(rdata_i, 3))); // R2

  AST_RD_MASK_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dqm_i[1], 2) |-> !dq_oe_o[1]); // R4

  AST_RD_MASK_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dqm_i[0], 2) |-> !dq_oe_o[0]); // R4

  AST_WR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd_i |=> (arr_we_o && arr_be_o == ~$past(dqm_i) && arr_wdata_o == $past(dq_i))); // R5

  AST_WR_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd_i |=> dq_oe_o == '0); // R8

  AST_STOP_CL2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_cmd_i && !lat3_q) |-> ##2 dq_oe_o == '0); // R6

  AST_STOP_CL3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_cmd_i && lat3_q) |-> ##3 dq_oe_o == '0); // R6

  AST_PRE_CL2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_cmd_i && !lat3_q) |-> ##2 dq_oe_o == '0); // R7

  AST_PRE_CL3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_cmd_i && lat3_q) |-> ##3 dq_oe_o == '0); // R7
endmodule

bind sdr_dq_path sdr_dq_path_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_set_i  (mode_set_i),
  .rd_cmd_i    (rd_cmd_i),
  .wr_cmd_i    (wr_cmd_i),
  .stop_cmd_i  (stop_cmd_i),
  .pre_cmd_i   (pre_cmd_i),
  .dqm_i       (dqm_i),
  .rdata_i     (rdata_i),
  .dq_i        (dq_i),
  .dq_o        (dq_o),
  .dq_oe_o     (dq_oe_o),
  .arr_we_o    (arr_we_o),
  .arr_be_o    (arr_be_o),
  .arr_wdata_o (arr_wdata_o),
  .lat3_q      (lat3_q)
);

// File: tb/sdr_dq_path_tb_top.sv
module sdr_dq_path_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        mode_set, mode_cl3, rd_cmd, wr_cmd, stop_cmd, pre_cmd, burst_end;
  logic [1:0]  dqm;
  logic [15:0] rdata, dq_in;
  logic [15:0] dq_out, arr_wdata;
  logic [1:0]  dq_oe, arr_be;
  logic        arr_we;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sdr_dq_path dut_i (
    .clk_i (clk), .rst_ni (rst_ni),
    .mode_set_i (mode_set), .mode_cl3_i (mode_cl3),
    .rd_cmd_i (rd_cmd), .wr_cmd_i (wr_cmd), .stop_cmd_i (stop_cmd), .pre_cmd_i (pre_cmd),
    .burst_end_i (burst_end), .dqm_i (dqm), .rdata_i (rdata), .dq_i (dq_in),
    .dq_o (dq_out), .dq_oe_o (dq_oe),
    .arr_we_o (arr_we), .arr_be_o (arr_be), .arr_wdata_o (arr_wdata)
  );

  typedef struct packed {
    logic        rd, wr, stp, pre, bend;
    logic [1:0]  msk;
    logic [1:0]  eoe;
    logic [15:0] edq;
    logic        ewe;
    logic [1:0]  ebe;
  } row_t;

  // run at latency 3; expected outputs are for the period after each row's edge
  localparam int NROW = 25;
  localparam row_t TBL [NROW] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,16'h0000,1'b0,2'b00}, // 0 idle
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,16'h0000,1'b0,2'b00}, // 1 read
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,16'h0000,1'b0,2'b00}, // 2 beat
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b11,16'hA001,1'b0,2'b00}, // 3 beat, row1 out
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b11,16'hA002,1'b0,2'b00}, // 4 lower mask
    '{1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b10,16'hA003,1'b0,2'b00}, // 5 last beat
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b11,16'hA004,1'b0,2'b00}, // 6
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b11,16'hA005,1'b0,2'b00}, // 7
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,16'h0000,1'b0,2'b00}, // 8 drained
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,16'h0000,1'b0,2'b00}, // 9 read
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,2'b00,16'h0000,1'b0,2'b00}, // 10 stop
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b11,16'hA009,1'b0,2'b00}, // 11
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,16'h0000,1'b0,2'b00}, // 12 floated
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,16'h0000,1'b0,2'b00}, // 13 read
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,16'h0000,1'b0,2'b00}, // 14 beat
    '{1'b0,1'b1,1'b0,1'b0,1'b1,2'b10,2'b00,16'h0000,1'b1,2'b01}, // 15 write cuts in
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,16'h0000,1'b0,2'b00}, // 16 flushed
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,16'h0000,1'b0,2'b00}, // 17 read
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,16'h0000,1'b0,2'b00}, // 18 beat
    '{1'b0,1'b0,1'b0,1'b1,1'b0,2'b00,2'b11,16'hA011,1'b0,2'b00}, // 19 precharge
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b11,16'hA012,1'b0,2'b00}, // 20
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,16'h0000,1'b0,2'b00}, // 21 floated
    '{1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,2'b00,16'h0000,1'b1,2'b11}, // 22 write burst
    '{1'b0,1'b0,1'b0,1'b0,1'b1,2'b11,2'b00,16'h0000,1'b1,2'b00}, // 23 masked beat
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,16'h0000,1'b0,2'b00}  // 24 idle
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic rd, input logic wr, input logic stp, input logic pre,
                      input logic bend, input logic [1:0] msk,
                      input logic [15:0] rdat, input logic [15:0] wdat);
    rd_cmd = rd; wr_cmd = wr; stop_cmd = stp; pre_cmd = pre;
    burst_end = bend; dqm = msk; rdata = rdat; dq_in = wdat;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0, 16'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; mode_set = 1'b0; mode_cl3 = 1'b0;
    rd_cmd = 1'b0; wr_cmd = 1'b0; stop_cmd = 1'b0; pre_cmd = 1'b0;
    burst_end = 1'b0; dqm = 2'b00; rdata = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", 32'(dq_oe), 32'h0);
    chk("R1 we in reset", 32'(arr_we), 32'h0);
    rst_ni = 1'b1;
    repeat (3) idle();
    chk("R1 oe after reset", 32'(dq_oe), 32'h0);

    // table walk at reset latency of three (R1, R2, R3, R4, R5, R6, R7, R8)
    for (int i = 0; i < NROW; i++) begin
      step(TBL[i].rd, TBL[i].wr, TBL[i].stp, TBL[i].pre, TBL[i].bend, TBL[i].msk,
           16'hA000 + 16'(i), 16'h5000 + 16'(i));
      chk($sformatf("R2/R4/R6/R7/R8 row %0d oe", i), 32'(dq_oe), 32'(TBL[i].eoe));
      if (TBL[i].eoe != 2'b00)
        chk($sformatf("R2/R3 row %0d dq", i), 32'(dq_out), 32'(TBL[i].edq));
      chk($sformatf("R5 row %0d we", i), 32'(arr_we), 32'(TBL[i].ewe));
      if (TBL[i].ewe) begin
        chk($sformatf("R5 row %0d be", i), 32'(arr_be), 32'(TBL[i].ebe));
        chk($sformatf("R5 row %0d wdata", i), 32'(arr_wdata), 32'h5000 + 32'(i));
      end
    end

    // switch to latency two
    idle();
    mode_set = 1'b1; mode_cl3 = 1'b0;
    idle();
    mode_set = 1'b0;
    idle();

    // R2 single word at latency two
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 16'h1234, 16'h0);
    chk("R2 cl2 not early", 32'(dq_oe), 32'h0);
    idle();
    chk("R2 cl2 oe", 32'(dq_oe), 32'h3);
    chk("R2 cl2 dq", 32'(dq_out), 32'h1234);
    idle();
    chk("R2 cl2 end", 32'(dq_oe), 32'h0);

    // R4 upper mask at latency two
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 16'h1111, 16'h0);
    chk("R4 first", 32'(dq_oe), 32'h0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 16'h2222, 16'h0);
    chk("R4 before mask takes hold", 32'(dq_oe), 32'h3);
    chk("R4 word one", 32'(dq_out), 32'h1111);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 16'h3333, 16'h0);
    chk("R4 upper byte off", 32'(dq_oe), 32'h1);
    chk("R4 word two", 32'(dq_out), 32'h2222);
    idle();
    chk("R4 mask released", 32'(dq_oe), 32'h3);
    chk("R3 last word", 32'(dq_out), 32'h3333);
    idle();
    chk("R3 burst ended", 32'(dq_oe), 32'h0);

    // R7 precharge at latency two
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 16'h4444, 16'h0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 16'h4545, 16'h0);
    chk("R7 cl2 last word", 32'(dq_out), 32'h4444);
    chk("R7 cl2 oe", 32'(dq_oe), 32'h3);
    idle();
    chk("R7 cl2 floated", 32'(dq_oe), 32'h0);

    // R6 stop at latency two
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 16'h7777, 16'h0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 16'h7878, 16'h0);
    chk("R6 cl2 last word", 32'(dq_out), 32'h7777);
    idle();
    chk("R6 cl2 floated", 32'(dq_oe), 32'h0);

    // R9 latency select ignored without a mode load
    mode_cl3 = 1'b1;
    idle();
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 16'h6666, 16'h0);
    idle();
    chk("R9 still two clocks oe", 32'(dq_oe), 32'h3);
    chk("R9 still two clocks dq", 32'(dq_out), 32'h6666);
    idle();

    // R1 reset mid-burst and latency back to three
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 16'h8888, 16'h0);
    idle();
    chk("R1 burst running", 32'(dq_oe), 32'h3);
    rst_ni = 1'b0;
    #1;
    chk("R1 oe async clear", 32'(dq_oe), 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    mode_cl3 = 1'b0;
    repeat (3) idle();
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 16'h9999, 16'h0);
    idle();
    chk("R1 latency three after reset", 32'(dq_oe), 32'h0);
    idle();
    chk("R1 cl3 oe", 32'(dq_oe), 32'h3);
    chk("R1 cl3 dq", 32'(dq_out), 32'h9999);
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule